// File: doc/BRIEF.md
# Variable-Length Frame Builder

The block turns one frame request plus a stream of 16-bit data words into a framed output word stream. A request carries a 4-bit length, a data-type bit, a label-present bit, a final-frame bit, a CRC-enable bit and a 16-bit label. Once a request is accepted, the builder asks the control-channel scheduler for a frame-header slot and waits for a grant. It then emits a sequence of words on a valid/ready output:

- a 12-bit Hamming-protected descriptor,
- the label, if the request has one,
- the data words,
- an 8-bit CRC, if the request enabled it.

Each output word is tagged with a 2-bit kind code, and the last word of the frame is flagged. Data words come from the input stream, which has its own valid/ready handshake. The builder passes them through without buffering. One frame is in flight at a time.

Top module: `vlf_builder`

## Requirements
- R1: During reset and in the first cycle after reset, `req_ready` is 1 and `out_valid`, `hdr_req` and `dat_ready` are 0.
- R2: After a request is accepted, `hdr_req` rises and stays high until `hdr_gnt` is seen. No output word is offered while `hdr_req` is high. The descriptor is offered in the cycle after the grant.
- R3: The first word of a frame has kind 0 and carries the descriptor in `out_data[11:0]`, with the upper bits zero. The information byte is {length[3:0], type, label_on, last, 0}, from bit 7 down to bit 0. Its bits 0..7 go to code positions 3,5,6,7,9,10,11,12. Even parity bits sit at positions 1,2,4,8. Code position p maps to `out_data[p-1]`.
- R4: When label_on is set, the word after the descriptor has kind 1 and equals the request label.
- R5: The length field gives the total of label plus data words, and a length of 0 means 16. The builder emits exactly (total − label_on) data words of kind 2, in input order and unchanged.
- R6: When the CRC is enabled, one last word of kind 3 carries the CRC in `out_data[7:0]`, with the upper bits zero. The CRC uses polynomial x^8+x^2+x+1 with initial value 0x00, and runs MSB first over the label and the data words. When the CRC is disabled, no kind-3 word is emitted.
- R7: `out_end` is 1 exactly on the final word of each frame.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1, with `out_data`, `out_kind` and `out_end` unchanged.
- R9: `req_ready` is 0 from the cycle after acceptance until the frame's final word has been taken.
- R10: In the data phase, `out_valid` follows `dat_valid`. `dat_ready` is 1 only in the data phase, and only when `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Builder can accept a request |
| req_len | input | 4 | Label plus data word count (0 = 16) |
| req_type | input | 1 | Data type: 0 configuration/monitoring, 1 raw |
| req_label_on | input | 1 | Frame carries a label word |
| req_last | input | 1 | Final frame of a packet |
| req_crc_on | input | 1 | Append CRC word |
| req_label | input | 16 | Label word |
| dat_valid | input | 1 | Data word present |
| dat_ready | output | 1 | Data word taken |
| dat_word | input | 16 | Data word |
| hdr_req | output | 1 | Request for a frame-header slot |
| hdr_gnt | input | 1 | Scheduler grant of the header slot |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 16 | Output word |
| out_kind | output | 2 | 0 descriptor, 1 label, 2 data, 3 CRC |
| out_end | output | 1 | Final word of the frame |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 4-bit length field and the 0x07 CRC polynomial. The short length field puts the wrapped value 0 (sixteen words) within a few hundred cycles, both with and without a label. The same holds for the label-only frame, where the length is 1 and no data words follow. The scenarios also combine scheduler grants delayed by several cycles with periodic output back-pressure and gaps in the input stream.

// File: rtl/vlf_pkg.sv
`timescale 1ns/1ps
package vlf_pkg;

  typedef enum logic [1:0] {
    KIND_DESC  = 2'd0,
    KIND_LABEL = 2'd1,
    KIND_PAY   = 2'd2,
    KIND_CRC   = 2'd3
  } word_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_DESC,
    ST_LABEL,
    ST_DATA,
    ST_CRC
  } seq_state_e;

  // Number of parity bits a single-error-correcting code needs for n info bits
  function automatic int ham_par_bits(input int n);
    int p;
    p = 0;
    while ((1 << p) < (n + p + 1)) p++;
    return p;
  endfunction

endpackage

// File: rtl/vlf_rst_sync.sv
`timescale 1ns/1ps
module vlf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/vlf_hamming_enc.sv
`timescale 1ns/1ps
module vlf_hamming_enc #(
  parameter  int INFO_W = 8,
  localparam int PAR_W  = vlf_pkg::ham_par_bits(INFO_W),
  localparam int CODE_W = INFO_W + PAR_W
) (
  input  logic [INFO_W-1:0] info,
  output logic [CODE_W-1:0] code
);

  logic [CODE_W:1] pos;

  always_comb begin
    int di;
    logic par;
    pos = '0;
    di  = 0;
    for (int q = 1; q <= CODE_W; q++) begin
      if ((q & (q - 1)) != 0) begin
        pos[q] = info[di];
        di++;
      end
    end
    for (int k = 0; k < PAR_W; k++) begin
      par = 1'b0;
      for (int q = 1; q <= CODE_W; q++) begin
        if (((q >> k) & 1) == 1 && q != (1 << k)) par = par ^ pos[q];
      end
      pos[1 << k] = par;
    end
  end

  assign code = pos[CODE_W:1];

endmodule

// File: rtl/vlf_crc_acc.sv
`timescale 1ns/1ps
module vlf_crc_acc #(
  parameter int              WORD_W = 16,
  parameter int              CRC_W  = 8,
  parameter logic [CRC_W-1:0] POLY  = 8'h07,
  parameter logic [CRC_W-1:0] INIT  = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc
);

  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    logic fb;
    crc_d = crc_q;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb    = crc_d[CRC_W-1] ^ word[i];
      crc_d = {crc_d[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= INIT;
    else if (clr) crc_q <= INIT;
    else if (en)  crc_q <= crc_d;
  end

  assign crc = crc_q;

  AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == INIT)) else $error("crc not cleared"); // R6

endmodule

// File: rtl/vlf_seq.sv
`timescale 1ns/1ps
module vlf_seq #(
  parameter  int LEN_W = 4,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  output logic             load,
  input  logic [CNT_W-1:0] cnt_load,
  input  logic             lab_q,
  input  logic             crc_q,
  output logic             hdr_req,
  input  logic             hdr_gnt,
  input  logic             dat_valid,
  output logic             dat_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic             out_end,
  output logic             crc_en
);
  import vlf_pkg::*;

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    req_ready = 1'b0;
    load      = 1'b0;
    hdr_req   = 1'b0;
    dat_ready = 1'b0;
    out_valid = 1'b0;
    out_kind  = KIND_DESC;
    out_end   = 1'b0;
    crc_en    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          load  = 1'b1;
          cnt_d = cnt_load;
          st_d  = ST_HDR;
        end
      end
      ST_HDR: begin
        hdr_req = 1'b1;
        if (hdr_gnt) st_d = ST_DESC;
      end
      ST_DESC: begin
        out_valid = 1'b1;
        if (out_ready) st_d = lab_q ? ST_LABEL : ST_DATA;
      end
      ST_LABEL: begin
        out_valid = 1'b1;
        out_kind  = KIND_LABEL;
        out_end   = (cnt_q == '0) && !crc_q;
        if (out_ready) begin
          crc_en = 1'b1;
          if (cnt_q != '0) st_d = ST_DATA;
          else             st_d = crc_q ? ST_CRC : ST_IDLE;
        end
      end
      ST_DATA: begin
        out_valid = dat_valid;
        dat_ready = out_ready;
        out_kind  = KIND_PAY;
        out_end   = (cnt_q == CNT_W'(1)) && !crc_q;
        if (dat_valid && out_ready) begin
          crc_en = 1'b1;
          cnt_d  = cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) st_d = crc_q ? ST_CRC : ST_IDLE;
        end
      end
      ST_CRC: begin
        out_valid = 1'b1;
        out_kind  = KIND_CRC;
        out_end   = 1'b1;
        if (out_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  AST_HDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_req && !hdr_gnt) |=> hdr_req) else $error("header request dropped"); // R2
  AST_DESC_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && out_kind == KIND_DESC) |-> $past(hdr_gnt)) else $error("descriptor without grant"); // R2
  AST_DATA_TAKEN_ON_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && dat_ready) |-> (out_valid && out_ready && out_kind == KIND_PAY)) else $error("data taken off-phase"); // R10

endmodule

// File: rtl/vlf_builder.sv
`timescale 1ns/1ps
module vlf_builder #(
  parameter  int               WORD_W   = 16,
  parameter  int               LEN_W    = 4,
  parameter  int               CRC_W    = 8,
  parameter  logic [CRC_W-1:0] CRC_POLY = 8'h07,
  parameter  logic [CRC_W-1:0] CRC_INIT = 8'h00,
  localparam int               INFO_W   = LEN_W + 4,
  localparam int               CODE_W   = INFO_W + vlf_pkg::ham_par_bits(INFO_W),
  localparam int               CNT_W    = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_type,
  input  logic              req_label_on,
  input  logic              req_last,
  input  logic              req_crc_on,
  input  logic [WORD_W-1:0] req_label,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [WORD_W-1:0] dat_word,
  output logic              hdr_req,
  input  logic              hdr_gnt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [1:0]        out_kind,
  output logic              out_end
);
  import vlf_pkg::*;

  logic              rst_s_n;
  logic              load, crc_en;
  logic [CNT_W-1:0]  total, cnt_load;
  logic [INFO_W-1:0] info_d, info_q;
  logic              lab_q, crc_on_q;
  logic [WORD_W-1:0] label_q;
  logic [CODE_W-1:0] desc_code;
  logic [CRC_W-1:0]  crc_val;
  logic [WORD_W-1:0] crc_in;

  vlf_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  // Length 0 wraps to the full 2**LEN_W words; label counts toward the total
  assign total    = (req_len == '0) ? CNT_W'(1 << LEN_W) : {1'b0, req_len};
  assign cnt_load = total - CNT_W'(req_label_on);
  assign info_d   = {req_len, req_type, req_label_on, req_last, 1'b0};

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      info_q   <= '0;
      lab_q    <= 1'b0;
      crc_on_q <= 1'b0;
      label_q  <= '0;
    end else if (load) begin
      info_q   <= info_d;
      lab_q    <= req_label_on;
      crc_on_q <= req_crc_on;
      label_q  <= req_label;
    end
  end

  vlf_hamming_enc #(.INFO_W(INFO_W)) ham_i (
    .info(info_q), .code(desc_code)
  );

  vlf_seq #(.LEN_W(LEN_W)) seq_i (
    .clk(clk), .rst_n(rst_s_n),
    .req_valid(req_valid), .req_ready(req_ready), .load(load),
    .cnt_load(cnt_load), .lab_q(lab_q), .crc_q(crc_on_q),
    .hdr_req(hdr_req), .hdr_gnt(hdr_gnt),
    .dat_valid(dat_valid), .dat_ready(dat_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_end(out_end), .crc_en(crc_en)
  );

  assign crc_in = (out_kind == KIND_LABEL) ? label_q : dat_word;

  vlf_crc_acc #(.WORD_W(WORD_W), .CRC_W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) crc_i (
    .clk(clk), .rst_n(rst_s_n), .clr(load), .en(crc_en),
    .word(crc_in), .crc(crc_val)
  );

  always_comb begin
    case (out_kind)
      KIND_DESC:  out_data = WORD_W'(desc_code);
      KIND_LABEL: out_data = label_q;
      KIND_PAY:   out_data = dat_word;
      default:    out_data = WORD_W'(crc_val);
    endcase
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_kind) && $stable(out_end)))
    else $error("output changed under stall"); // R8
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> !req_ready) else $error("request accepted mid-frame"); // R9
  AST_END_NOT_DESC: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_valid && out_end) |-> (out_kind != KIND_DESC)) else $error("frame ended on descriptor"); // R7
  AST_NO_OUT_IN_HDR: assert property (@(posedge clk) disable iff (!rst_s_n)
    hdr_req |-> !out_valid) else $error("output during header request"); // R2

endmodule

// File: tb/vlf_builder_tb_top.sv
`timescale 1ns/1ps
module vlf_builder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [3:0]  req_len;
  logic        req_type, req_label_on, req_last, req_crc_on;
  logic [15:0] req_label;
  logic        dat_valid, dat_ready;
  logic [15:0] dat_word;
  logic        hdr_req, hdr_gnt;
  logic        out_valid, out_ready;
  logic [15:0] out_data;
  logic [1:0]  out_kind;
  logic        out_end;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vlf_builder dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
    .req_type(req_type), .req_label_on(req_label_on), .req_last(req_last),
    .req_crc_on(req_crc_on), .req_label(req_label),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_word(dat_word),
    .hdr_req(hdr_req), .hdr_gnt(hdr_gnt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_kind(out_kind), .out_end(out_end)
  );

  logic [15:0] e_data [0:19];
  logic [1:0]  e_kind [0:19];
  logic        e_end  [0:19];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] ham12(input logic [7:0] info);
    logic [12:0] c;
    int di;
    c  = '0;
    di = 0;
    for (int p = 1; p <= 12; p++)
      if (p != 1 && p != 2 && p != 4 && p != 8) begin c[p] = info[di]; di++; end
    for (int b = 1; b <= 8; b = b * 2)
      for (int q = 1; q <= 12; q++)
        if ((q & b) != 0 && q != b) c[b] = c[b] ^ c[q];
    return c[12:1];
  endfunction

  function automatic logic [7:0] crc_word(input logic [7:0] crc, input logic [15:0] w);
    logic [7:0] r;
    logic fb;
    r = crc;
    for (int i = 15; i >= 0; i--) begin
      fb = r[7] ^ w[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  function automatic logic [15:0] dword(input int seed, input int i);
    return 16'(seed * 16'h0913 + i * 16'h3C5B + 16'h0101);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 0; req_len = 0; req_type = 0; req_label_on = 0;
    req_last = 0; req_crc_on = 0; req_label = 0; dat_valid = 0; dat_word = 0;
    hdr_gnt = 0; out_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !out_valid && !hdr_req && !dat_ready, "R1", "outputs in reset",
        {req_ready, out_valid, hdr_req, dat_ready}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !out_valid && !hdr_req && !dat_ready, "R1", "outputs after reset",
        {req_ready, out_valid, hdr_req, dat_ready}, 4'b1000);
    @(posedge clk); #1;
  endtask

  // One frame end to end; pat bit0 stalls out_ready, bit1 gaps dat_valid
  task automatic run_frame(input int seed, input logic [3:0] len, input logic typ,
                           input logic lab, input logic last, input logic crc_on,
                           input logic [15:0] label, input int gnt_dly, input int pat);
    int total, ndata, n, opos, dpos, gcnt, cyc;
    logic [7:0] crc;
    bit req_done, prev_stall, dhs, ohs;
    logic [15:0] pd; logic [1:0] pk; logic pe;
    total = (len == 0) ? 16 : int'(len);
    ndata = total - int'(lab);
    n = 0; crc = 8'h00;
    e_data[n] = {4'h0, ham12({len, typ, lab, last, 1'b0})}; e_kind[n] = 2'd0; n++;
    if (lab) begin e_data[n] = label; e_kind[n] = 2'd1; crc = crc_word(crc, label); n++; end
    for (int i = 0; i < ndata; i++) begin
      e_data[n] = dword(seed, i); e_kind[n] = 2'd2; crc = crc_word(crc, dword(seed, i)); n++;
    end
    if (crc_on) begin e_data[n] = {8'h00, crc}; e_kind[n] = 2'd3; n++; end
    for (int i = 0; i < n; i++) e_end[i] = (i == n - 1);

    req_valid = 1; req_len = len; req_type = typ; req_label_on = lab;
    req_last = last; req_crc_on = crc_on; req_label = label;
    out_ready = 1; dat_valid = 0; dat_word = dword(seed, 0); hdr_gnt = 0;
    opos = 0; dpos = 0; gcnt = 0; cyc = 0; req_done = 0; prev_stall = 0;
    pd = 0; pk = 0; pe = 0;
    while (opos < n && cyc < 400) begin
      @(negedge clk);
      if (hdr_req && out_valid) chk(0, "R2", "output during header request", 1, 0);
      if (req_done && req_ready) chk(0, "R9", "req_ready high mid-frame", 1, 0);
      if (prev_stall)
        chk(out_valid && out_data == pd && out_kind == pk && out_end == pe, "R8",
            "held word", {out_valid, 1'b0, out_kind, out_data}, {1'b1, 1'b0, pk, pd});
      if (out_kind == 2'd2 && !hdr_req && opos > 0)
        chk(out_valid == dat_valid, "R10", "valid follows input", out_valid, dat_valid);
      if (dat_ready && !(out_kind == 2'd2 && out_ready))
        chk(0, "R10", "dat_ready outside data phase", 1, 0);
      dhs = dat_valid && dat_ready;
      ohs = out_valid && out_ready;
      if (ohs) begin
        case (e_kind[opos])
          2'd0:    chk(out_kind == 0 && out_data == e_data[opos], "R3", "descriptor", {out_kind, out_data}, {e_kind[opos], e_data[opos]});
          2'd1:    chk(out_kind == 1 && out_data == e_data[opos], "R4", "label", {out_kind, out_data}, {e_kind[opos], e_data[opos]});
          2'd2:    chk(out_kind == 2 && out_data == e_data[opos], "R5", "data word", {out_kind, out_data}, {e_kind[opos], e_data[opos]});
          default: chk(out_kind == 3 && out_data == e_data[opos], "R6", "crc word", {out_kind, out_data}, {e_kind[opos], e_data[opos]});
        endcase
        chk(out_end == e_end[opos], "R7", "end flag", out_end, e_end[opos]);
        opos++;
      end
      prev_stall = out_valid && !out_ready;
      pd = out_data; pk = out_kind; pe = out_end;
      if (req_valid && req_ready) req_done = 1;
      if (dhs) dpos++;
      if (hdr_req) gcnt++;
      @(posedge clk); #1;
      cyc++;
      req_valid = !req_done;
      hdr_gnt   = hdr_req && (gcnt > gnt_dly);
      out_ready = !(pat[0] && (cyc % 3 == 1));
      if (!(dat_valid && !dhs))
        dat_valid = (dpos < ndata) && !(pat[1] && (cyc % 4 == 2));
      dat_word = dword(seed, dpos);
    end
    chk(opos == n, "R5", "frame length", opos, n);
    chk(gcnt > gnt_dly, "R2", "header request lasted until grant", gcnt, gnt_dly + 1);
    req_valid = 0; dat_valid = 0; hdr_gnt = 0; out_ready = 1;
    @(posedge clk); #1;
  endtask

  task automatic t_plain();        run_frame(1, 4'd3, 0, 0, 0, 0, 16'h0000, 0, 0); endtask
  task automatic t_label_crc();    run_frame(2, 4'd5, 1, 1, 1, 1, 16'hBEEF, 2, 0); endtask
  task automatic t_len16_label();  run_frame(3, 4'd0, 0, 1, 0, 1, 16'h1234, 1, 3); endtask
  task automatic t_len16_plain();  run_frame(4, 4'd0, 1, 0, 1, 0, 16'h0000, 0, 1); endtask
  task automatic t_label_only();   run_frame(5, 4'd1, 1, 1, 1, 0, 16'hA5C3, 0, 1); endtask
  task automatic t_label_crc_only(); run_frame(6, 4'd1, 0, 1, 0, 1, 16'h8001, 3, 0); endtask
  task automatic t_slow_grant();   run_frame(7, 4'd2, 0, 0, 1, 1, 16'h0000, 7, 2); endtask
  task automatic t_back_to_back();
    run_frame(8, 4'd4, 1, 0, 0, 1, 16'h0000, 0, 3);
    run_frame(9, 4'd15, 0, 1, 1, 1, 16'h7E7E, 1, 2);
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "R1", "watchdog expired", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    t_plain();
    t_label_crc();
    t_len16_label();
    t_len16_plain();
    t_label_only();
    t_label_crc_only();
    t_slow_grant();
    t_back_to_back();
    @(negedge clk);
    chk(req_ready && !out_valid && !hdr_req, "R9", "idle after last frame",
        {req_ready, out_valid, hdr_req}, 3'b100);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule